// File: doc/BRIEF.md
# SM3 Message Expansion Scheduler

This block feeds the compression core of an SM3-style hash with its per-round message operands. When a 512-bit message block is presented with a start strobe, the block captures the sixteen 32-bit words. For every round j from 0 to 63 it then presents the word W_j together with the paired word W'_j = W_j XOR W_{j+4}. The compression core moves the block to the next round with a one-cycle advance strobe. Padding and length encoding are handled elsewhere.

The full 68-word schedule is never stored. Words beyond the sixteen loaded ones are produced on the fly into a 17-slot circular window addressed modulo 17. Each new word overwrites the one slot whose word no round will read again. Expansion starts at round 12, so that the word four positions ahead exists when each round begins.

A two-state controller sequences the block. The state ST_IDLE moves to ST_RUN on a start strobe. ST_RUN stays in ST_RUN on a further start strobe, which restarts the schedule. ST_RUN returns to ST_IDLE on an advance strobe taken in round 63.

Top module: `wexp_sched`

## Requirements
- R1: After reset, `w_valid` is 0, and `w_word` and `w_pair` are 0. Both data outputs stay 0 whenever `w_valid` is 0.
- R2: Input word i (0..15) is `blk_data[511-32*i -: 32]`. Its first byte, at the higher bit positions, is the most significant byte. For example, the block whose bytes are 00,01,02,... in order gives W_0 = 0x00010203.
- R3: `w_valid` is 1 in the cycle after a start strobe (`blk_load`=1 at a clock edge), and the outputs then show round 0: W_0 and W_0^W_4.
- R4: In rounds 0 to 11, `w_pair` is W_j^W_{j+4}, taken only from the sixteen loaded words.
- R5: For j of 16 and above, W_j = P1(W_{j-16} ^ W_{j-9} ^ rotl(W_{j-3},15)) ^ rotl(W_{j-13},7) ^ W_{j-6}. Rounds 12 to 63 present W_j and W_j^W_{j+4} using these words, held in a 17-slot window addressed modulo 17.
- R6: P1(x) = x ^ rotl(x,15) ^ rotl(x,23), where rotl is a 32-bit left rotation.
- R7: An advance strobe (`round_step`=1) taken while `w_valid` is 0 has no effect. `w_valid` stays 0 and the outputs stay 0.
- R8: One block gives exactly 64 rounds. An advance strobe taken in round 63 drops `w_valid` in the next cycle.
- R9: A start strobe in the middle of a block abandons that block. The next cycle shows round 0 of the new block.
- R10: While `w_valid` is 1 and neither strobe is given, `w_word` and `w_pair` hold their values.
- R11: When the start and advance strobes arrive at the same edge, the start strobe wins and round 0 of the new block follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| blk_load | input | 1 | Start strobe: capture `blk_data` and begin round 0 |
| blk_data | input | 512 | Message block, word 0 in the top 32 bits |
| round_step | input | 1 | Advance strobe from the compression core |
| w_word | output | 32 | Current round word W_j |
| w_pair | output | 32 | Current paired word W_j ^ W_{j+4} |
| w_valid | output | 1 | Schedule outputs are meaningful |

## Verification
The hardest point to reach is the window wrap. From round 12 onward, every new word lands in a slot that an earlier word occupied, and the slot index wraps past 16. An error in slot reuse or in the tap offsets shows up only in later rounds. The bench therefore walks several complete blocks, each with a different word pattern, and compares every round against a schedule model computed in the bench. It also aborts one block after the wrap has started, and starts another block in the same edge as an advance strobe. This shows that the restart clears the window position and the round count.

// File: rtl/hws_pkg.sv
package hws_pkg;

    localparam int WORD_W     = 32;
    localparam int NUM_IN     = 16;
    localparam int WIN_DEPTH  = 17;
    localparam int NUM_ROUNDS = 64;
    localparam int EXP_FIRST  = 12;
    localparam int AHEAD      = 4;

    localparam int PTR_W = $clog2(WIN_DEPTH);
    localparam int RND_W = $clog2(NUM_ROUNDS);
    localparam int BLK_W = WORD_W * NUM_IN;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [RND_W-1:0]  rnd_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } sched_state_e;

    function automatic word_t rotl(input word_t x, input int unsigned n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    function automatic word_t p1(input word_t x);
        return x ^ rotl(x, 15) ^ rotl(x, 23);
    endfunction

    // slot that lies off positions after base, modulo the window depth
    function automatic ptr_t slot_of(input ptr_t base, input int unsigned off);
        int unsigned s;
        s = int'(base) + off;
        if (s >= WIN_DEPTH) s = s - WIN_DEPTH;
        return ptr_t'(s);
    endfunction

endpackage

// File: rtl/hws_ctrl.sv
module hws_ctrl
    import hws_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic step_i,
    output logic valid_o,
    output logic expand_o,
    output logic wr_o,
    output ptr_t ptr_o
);

    sched_state_e state_q, state_d;
    rnd_t         rnd_q;
    ptr_t         ptr_q;
    logic         last_rnd;
    logic         advance;

    assign last_rnd = (rnd_q == rnd_t'(NUM_ROUNDS - 1));
    assign advance  = (state_q == ST_RUN) && step_i && !load_i;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load_i) state_d = ST_RUN;
            ST_RUN: begin
                if (load_i)                  state_d = ST_RUN;
                else if (step_i && last_rnd) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // round counter and window pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rnd_q <= '0;
            ptr_q <= '0;
        end else if (load_i) begin
            rnd_q <= '0;
            ptr_q <= '0;
        end else if (advance) begin
            rnd_q <= rnd_q + rnd_t'(1);
            ptr_q <= slot_of(ptr_q, 1);
        end
    end

    // outputs
    always_comb begin
        valid_o  = (state_q == ST_RUN);
        expand_o = (rnd_q >= rnd_t'(EXP_FIRST));
        wr_o     = advance && expand_o;
        ptr_o    = ptr_q;
    end

    AST_VALID_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> valid_o); // R3
    AST_IDLE_STEP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && step_i && !load_i) |=> !valid_o); // R7
    AST_LAST_ROUND_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && step_i && !load_i && last_rnd) |=> !valid_o); // R8
    AST_PTR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q < ptr_t'(WIN_DEPTH)); // R5

endmodule

// File: rtl/hws_window.sv
module hws_window
    import hws_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [BLK_W-1:0] blk_i,
    input  logic             wr_i,
    input  logic             expand_i,
    input  logic             valid_i,
    input  ptr_t             ptr_i,
    output word_t            w_o,
    output word_t            wp_o
);

    // tap offsets relative to the current round slot, for the word j+AHEAD
    localparam int OFF_NEW = AHEAD;
    localparam int OFF_M16 = WIN_DEPTH + AHEAD - 16;
    localparam int OFF_M13 = WIN_DEPTH + AHEAD - 13;
    localparam int OFF_M9  = WIN_DEPTH + AHEAD - 9;
    localparam int OFF_M6  = WIN_DEPTH + AHEAD - 6;
    localparam int OFF_M3  = AHEAD - 3;

    word_t win [WIN_DEPTH];
    word_t new_word;
    word_t ahead_word;
    word_t cur_word;
    ptr_t  new_slot;

    assign new_slot = slot_of(ptr_i, OFF_NEW);

    for (genvar s = 0; s < WIN_DEPTH; s++) begin : g_slot
        word_t slot_q;
        word_t load_val;
        if (s < NUM_IN) begin : g_in
            assign load_val = blk_i[BLK_W-1-s*WORD_W -: WORD_W];
        end else begin : g_spare
            assign load_val = '0;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                slot_q <= '0;
            else if (load_i)                           slot_q <= load_val;
            else if (wr_i && (new_slot == ptr_t'(s))) slot_q <= new_word;
        end
        assign win[s] = slot_q;
    end

    always_comb begin
        new_word = p1(win[slot_of(ptr_i, OFF_M16)] ^ win[slot_of(ptr_i, OFF_M9)]
                      ^ rotl(win[slot_of(ptr_i, OFF_M3)], 15))
                   ^ rotl(win[slot_of(ptr_i, OFF_M13)], 7)
                   ^ win[slot_of(ptr_i, OFF_M6)];
        cur_word   = win[ptr_i];
        ahead_word = expand_i ? new_word : win[new_slot];
        w_o        = valid_i ? cur_word : '0;
        wp_o       = valid_i ? (cur_word ^ ahead_word) : '0;
    end

    AST_FIRST_WORD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (w_o == $past(blk_i[BLK_W-1 -: WORD_W]))); // R2
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |-> (w_o == '0 && wp_o == '0)); // R1

endmodule

// File: rtl/wexp_sched.sv
module wexp_sched
    import hws_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         blk_load,
    input  logic [511:0] blk_data,
    input  logic         round_step,
    output logic [31:0]  w_word,
    output logic [31:0]  w_pair,
    output logic         w_valid
);

    logic valid_s;
    logic expand_s;
    logic wr_s;
    ptr_t ptr_s;

    hws_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (blk_load),
        .step_i   (round_step),
        .valid_o  (valid_s),
        .expand_o (expand_s),
        .wr_o     (wr_s),
        .ptr_o    (ptr_s)
    );

    hws_window u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (blk_load),
        .blk_i    (blk_data),
        .wr_i     (wr_s),
        .expand_i (expand_s),
        .valid_i  (valid_s),
        .ptr_i    (ptr_s),
        .w_o      (w_word),
        .wp_o     (w_pair)
    );

    assign w_valid = valid_s;

    AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && !round_step && !blk_load) |=> ($stable(w_word) && $stable(w_pair))); // R10

endmodule

// File: tb/wexp_sched_tb.sv
module wexp_sched_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         blk_load = 1'b0;
    logic [511:0] blk_data = '0;
    logic         round_step = 1'b0;
    logic [31:0]  w_word;
    logic [31:0]  w_pair;
    logic         w_valid;

    int checks = 0;
    int errors = 0;

    logic [31:0] ref_w [68];
    logic [31:0] q_w [$];
    logic [31:0] q_wp [$];
    string       q_tag [$];
    event        ev_chk;

    always #5 clk = ~clk;

    wexp_sched u_dut (
        .clk(clk), .rst_n(rst_n), .blk_load(blk_load), .blk_data(blk_data),
        .round_step(round_step), .w_word(w_word), .w_pair(w_pair), .w_valid(w_valid)
    );

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic logic [31:0] pp(input logic [31:0] x);
        return x ^ rl(x, 15) ^ rl(x, 23);
    endfunction

    task automatic build_ref(input logic [511:0] b);
        for (int i = 0; i < 16; i++) ref_w[i] = b[511-32*i -: 32];
        for (int j = 16; j < 68; j++)
            ref_w[j] = pp(ref_w[j-16] ^ ref_w[j-9] ^ rl(ref_w[j-3], 15))
                       ^ rl(ref_w[j-13], 7) ^ ref_w[j-6];
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver side: queue the expected pair for round j of the current reference
    task automatic expect_round(input int j, input string tag);
        q_w.push_back(ref_w[j]);
        q_wp.push_back(ref_w[j] ^ ref_w[j+4]);
        q_tag.push_back(tag);
        -> ev_chk;
    endtask

    // monitor: compare the design outputs with the queued item
    initial begin
        forever begin
            @(ev_chk);
            while (q_w.size() > 0) begin
                logic [31:0] ew, ewp;
                string t;
                ew = q_w.pop_front();
                ewp = q_wp.pop_front();
                t = q_tag.pop_front();
                check(w_valid === 1'b1, {t, " valid"}, {31'b0, w_valid}, 32'd1);
                check(w_word === ew, {t, " word"}, w_word, ew);
                check(w_pair === ewp, {t, " pair"}, w_pair, ewp);
            end
        end
    end

    task automatic do_load(input logic [511:0] b, input bit with_step);
        @(negedge clk);
        blk_data = b;
        blk_load = 1'b1;
        round_step = with_step;
        @(negedge clk);
        blk_load = 1'b0;
        round_step = 1'b0;
        build_ref(b);
    endtask

    task automatic do_step();
        @(negedge clk);
        round_step = 1'b1;
        @(negedge clk);
        round_step = 1'b0;
    endtask

    function automatic logic [511:0] pattern(input logic [31:0] mul, input logic [31:0] add);
        logic [511:0] b;
        for (int i = 0; i < 16; i++) b[511-32*i -: 32] = mul * (i + 1) + add;
        return b;
    endfunction

    task automatic check_idle(input string tag);
        check(w_valid === 1'b0, {tag, " valid low"}, {31'b0, w_valid}, 32'd0);
        check(w_word === 32'd0, {tag, " word zero"}, w_word, 32'd0);
        check(w_pair === 32'd0, {tag, " pair zero"}, w_pair, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [511:0] blk_a, blk_b, blk_c, blk_d;
        for (int k = 0; k < 64; k++) blk_a[511-8*k -: 8] = 8'(k);
        blk_b = pattern(32'h9E3779B9, 32'h0000_1234);
        blk_c = pattern(32'h0101_0101, 32'hFEDC_BA98);
        blk_d = pattern(32'h7F4A_7C15, 32'h3C6E_F372);

        repeat (3) @(negedge clk);
        check_idle("R1 reset");
        rst_n = 1'b1;

        // R7: advance strobes with no block running
        do_step();
        do_step();
        check_idle("R7 step while idle");

        // block A, all 64 rounds
        do_load(blk_a, 1'b0);
        check(w_word === 32'h00010203, "R2 byte order of word 0", w_word, 32'h00010203);
        expect_round(0, "R3 round 0");
        for (int j = 1; j < 64; j++) begin
            do_step();
            if (j < 12) expect_round(j, $sformatf("R4 round %0d", j));
            else        expect_round(j, $sformatf("R5,R6 round %0d", j));
        end
        do_step();
        check_idle("R8 after round 63");
        do_step();
        check_idle("R7 step after block end");

        // block B with a stall, then abandoned after the window wrapped
        do_load(blk_b, 1'b0);
        expect_round(0, "R3 block B round 0");
        for (int j = 1; j <= 20; j++) begin
            do_step();
            expect_round(j, $sformatf("R5 block B round %0d", j));
            if (j == 7 || j == 18) begin
                repeat (3) @(negedge clk);
                expect_round(j, $sformatf("R10 hold at round %0d", j));
            end
        end

        // R9: restart mid-block with block C, run it to the end
        do_load(blk_c, 1'b0);
        expect_round(0, "R9 restart round 0");
        for (int j = 1; j < 64; j++) begin
            do_step();
            expect_round(j, $sformatf("R9 R5 block C round %0d", j));
        end
        do_step();
        check_idle("R8 block C end");

        // R11: start and advance in the same edge
        do_load(blk_b, 1'b0);
        for (int j = 1; j <= 14; j++) do_step();
        do_load(blk_d, 1'b1);
        expect_round(0, "R11 load beats step round 0");
        for (int j = 1; j < 20; j++) begin
            do_step();
            expect_round(j, $sformatf("R11 block D round %0d", j));
        end

        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule